// File: doc/BRIEF.md
# Sample Clock Phase Tuning Engine

This block is a hardware sequencer that finds a good receive sampling phase for a memory-card host. A start pulse begins a scan over a parameterised set of phases (eight by default, 45 degrees apart). For each phase the engine does three things in order. It puts the phase index on its select output. It pulses a clear of every interrupt status bit. It then asks an external command engine to issue one tuning command, over a request/acknowledge handshake that returns a pass or fail result.

During the scan the engine watches the pass/fail results for two kinds of change. A change from fail to pass gives the raise point. A change from pass to fail gives the fall point. The scan stops once both points are known, or after the last phase. The engine then pulses the interrupt clear once more. If any phase passed, it leaves the select on a computed centre of the passing window and raises done. If no phase passed, it returns the select to index 0 and raises done and error together.

Top module: `phase_tune_seq`

## Requirements
- R1: Phases are tried in ascending order starting at index 0, with exactly one command per phase. While a request is outstanding, the select output holds that phase's index.
- R2: Before each request, irq_clr_o is all ones (0x1FFFF with 17 bits) for exactly one cycle. One more such cycle follows the last attempt, before done rises. At all other times irq_clr_o is zero.
- R3: cmd_req_o stays high until the cycle in which cmd_ack_i is high. cmd_pass_i is ignored in every other cycle.
- R4: From index 1 on, a pass at the previous index followed by a fail at the current index records the fall point as the previous index.
- R5: From index 1 on, a fail at the previous index followed by a pass at the current index records the raise point as the current index.
- R6: As soon as both a raise point and a fall point are known, no further phases are tried.
- R7: If at least one attempt passed, a missing raise point counts as 0 and a missing fall point counts as the last index (7).
- R8: If fall >= raise, the final index is (raise + fall) / 2, truncated.
- R9: If fall < raise, the final index is fall / 2 when raise + fall > 7. Otherwise it is (raise + 7) / 2, truncated.
- R10: If no attempt passed, done_o and error_o are both 1 and phase_sel_o is 0. On success done_o is 1 and error_o is 0. Both outputs hold until the next accepted start.
- R11: A start pulse that arrives while busy_o is high has no effect on the scan or on its result.
- R12: After reset, busy_o, done_o, error_o, cmd_req_o, irq_clr_o and phase_sel_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| irq_clr_o | output | 17 | Interrupt status clear strobe, all ones when active |
| cmd_req_o | output | 1 | Tuning command request |
| cmd_ack_i | input | 1 | One-cycle acknowledge from the command engine |
| cmd_pass_i | input | 1 | Command result, valid only with cmd_ack_i |
| phase_sel_o | output | 3 | Sampling phase index |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan finished, held until the next start |
| error_o | output | 1 | No passing phase was found |

## Verification
The bench aims at the window edge cases: every phase passing, none passing, a single passing phase at either end, and windows that wrap past the last index with raise + fall on either side of 7. An engine that mishandled these would land on the wrong centre or report a false error. Patterns whose two edges appear early make sure the command count shrinks, which catches an engine that fails to stop its scan early. Acknowledges come after random delays, and cmd_pass_i carries random junk outside the acknowledge cycle, so an engine that sampled the result at the wrong time would record false edges. One scan also receives a stray start mid-way, to show that a busy engine does not restart.

// File: rtl/phase_tune_seq.sv
module phase_tune_seq #(
  parameter int NPH  = 8,
  parameter int CLRW = 17,
  localparam int IW  = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic [CLRW-1:0] irq_clr_o,
  output logic            cmd_req_o,
  input  logic            cmd_ack_i,
  input  logic            cmd_pass_i,
  output logic [IW-1:0]   phase_sel_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            error_o
);
  localparam int PW = IW + 1;
  localparam logic [PW:0] LAST = (PW+1)'(NPH - 1);

  typedef enum logic [1:0] {S_IDLE, S_CLR, S_REQ, S_FIN} st_t;
  st_t st;

  logic [IW-1:0] idx, phase_r;
  logic [PW-1:0] rpt, fpt;
  logic rv, fv, prev_pass, any_pass, done_r, err_r;

  logic hit, rise_ev, fall_ev, stop_now;
  logic [PW:0] r_eff, f_eff, pick;

  assign hit      = (st == S_REQ) && cmd_ack_i;
  assign rise_ev  = (idx != '0) && !prev_pass && cmd_pass_i;
  assign fall_ev  = (idx != '0) && prev_pass && !cmd_pass_i;
  assign stop_now = (idx == IW'(NPH - 1)) || ((rv || rise_ev) && (fv || fall_ev));

  assign r_eff = rv ? {1'b0, rpt} : '0;
  assign f_eff = fv ? {1'b0, fpt} : LAST;

  always_comb begin
    if (f_eff >= r_eff)             pick = (r_eff + f_eff) >> 1;
    else if (r_eff + f_eff > LAST)  pick = f_eff >> 1;
    else                            pick = (r_eff + LAST) >> 1;
  end

  assign irq_clr_o   = (st == S_CLR || st == S_FIN) ? '1 : '0;
  assign cmd_req_o   = (st == S_REQ);
  assign busy_o      = (st != S_IDLE);
  assign phase_sel_o = phase_r;
  assign done_o      = done_r;
  assign error_o     = err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      phase_r   <= '0;
      rpt       <= '0;
      fpt       <= '0;
      rv        <= 1'b0;
      fv        <= 1'b0;
      prev_pass <= 1'b0;
      any_pass  <= 1'b0;
      done_r    <= 1'b0;
      err_r     <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st       <= S_CLR;
          idx      <= '0;
          phase_r  <= '0;
          rv       <= 1'b0;
          fv       <= 1'b0;
          any_pass <= 1'b0;
          done_r   <= 1'b0;
          err_r    <= 1'b0;
        end
        S_CLR: st <= S_REQ;
        S_REQ: if (hit) begin
          prev_pass <= cmd_pass_i;
          if (cmd_pass_i) any_pass <= 1'b1;
          if (rise_ev) begin rv <= 1'b1; rpt <= PW'(idx); end
          if (fall_ev) begin fv <= 1'b1; fpt <= PW'(idx) - 1'b1; end
          if (stop_now) st <= S_FIN;
          else begin
            st      <= S_CLR;
            idx     <= idx + 1'b1;
            phase_r <= idx + 1'b1;
          end
        end
        S_FIN: begin
          st      <= S_IDLE;
          phase_r <= any_pass ? IW'(pick) : '0;
          done_r  <= 1'b1;
          err_r   <= !any_pass;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_tune_chk.sv
module phase_tune_chk #(
  parameter int NPH  = 8,
  parameter int CLRW = 17,
  localparam int IW  = $clog2(NPH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [CLRW-1:0] irq_clr_o,
  input logic            cmd_req_o,
  input logic            cmd_ack_i,
  input logic            cmd_pass_i,
  input logic [IW-1:0]   phase_sel_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            error_o
);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && !cmd_ack_i |=> cmd_req_o);

  assert_phase_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o && !cmd_ack_i |=> $stable(phase_sel_o));

  assert_clr_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_req_o) |-> $past(irq_clr_o) == {CLRW{1'b1}});

  assert_clr_before_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(irq_clr_o) == {CLRW{1'b1}});

  assert_err_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> done_o && phase_sel_o == '0);

  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_req_o && irq_clr_o == '0);
endmodule

bind phase_tune_seq phase_tune_chk #(.NPH(NPH), .CLRW(CLRW)) u_chk (.*);

// File: tb/test_phase_tune_seq.sv
module test_phase_tune_seq;
  logic clk = 0, rst_n = 0, start_i = 0, cmd_ack_i = 0, cmd_pass_i = 0;
  logic [16:0] irq_clr_o;
  logic cmd_req_o, busy_o, done_o, error_o;
  logic [2:0] phase_sel_o;
  logic [7:0] pat;
  int checks = 0, fails = 0, ncmd = 0, nclr = 0, order_bad = 0, dly = 0;

  always #2.5 clk = ~clk;

  phase_tune_seq i_phase_tune_seq (.*);

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  // returns {err, index[2:0], ncmd[3:0]}
  function automatic logic [7:0] model(input logic [7:0] p);
    int r = -1, f = -1, n = 0, k;
    bit any = 0;
    for (int i = 0; i < 8; i++) begin
      n++;
      if (p[i]) any = 1;
      if (i > 0 && !p[i] && p[i-1]) f = i - 1;
      if (i > 0 && p[i] && !p[i-1]) r = i;
      if (r != -1 && f != -1) break;
    end
    if (!any) return {1'b1, 3'd0, 4'(n)};
    if (r == -1) r = 0;
    if (f == -1) f = 7;
    if (f >= r) k = (r + f) / 2;
    else if (r + f > 7) k = f / 2;
    else k = (r + 7) / 2;
    return {1'b0, 3'(k), 4'(n)};
  endfunction

  // command engine model: random latency, junk result outside ack
  initial begin
    forever begin
      @(negedge clk);
      cmd_ack_i = 0;
      cmd_pass_i = 1'($urandom);
      if (irq_clr_o == '1) nclr++;
      else if (irq_clr_o != '0) order_bad++;
      if (cmd_req_o) begin
        if (dly == 0) begin
          if (phase_sel_o != 3'(ncmd)) order_bad++;
          cmd_ack_i = 1;
          cmd_pass_i = pat[phase_sel_o];
          ncmd++;
          dly = int'($urandom % 4);
        end else dly--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic run(input logic [7:0] p, input bit poke, input string tag);
    logic [7:0] e;
    int cyc = 0;
    e = model(p);
    pat = p; ncmd = 0; nclr = 0; order_bad = 0;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    while (!done_o && cyc < 400) begin
      @(negedge clk);
      cyc++;
      start_i = poke && (cyc == 4);
    end
    start_i = 0;
    chk(done_o, {tag, " R10 done"}, int'(done_o), 1);
    chk(error_o == e[7], {tag, " R10 error"}, int'(error_o), int'(e[7]));
    chk(phase_sel_o == e[6:4], {tag, " R8 R9 R7 phase"}, int'(phase_sel_o), int'(e[6:4]));
    chk(ncmd == int'(e[3:0]), {tag, " R6 R4 R5 commands"}, ncmd, int'(e[3:0]));
    chk(nclr == ncmd + 1, {tag, " R2 clears"}, nclr, ncmd + 1);
    chk(order_bad == 0, {tag, " R1 R3 order"}, order_bad, 0);
    chk(!busy_o, {tag, " R11 idle"}, int'(busy_o), 0);
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    pat = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !error_o && !cmd_req_o && irq_clr_o == 0 && phase_sel_o == 0,
        "R12 reset", int'({busy_o, done_o, error_o, cmd_req_o}), 0);
    rst_n = 1;
    @(negedge clk);
    run(8'h00, 0, "none_pass R10");
    run(8'hFF, 0, "all_pass R7");
    run(8'h3C, 0, "mid_window R8");
    run(8'hC3, 0, "wrap_low R9");
    run(8'h8F, 0, "wrap_high R9");
    run(8'h81, 0, "ends_only R9");
    run(8'hE1, 1, "busy_start R11");
    run(8'h01, 0, "first_only R7");
    run(8'h80, 0, "last_only R7");
    run(8'h05, 0, "early_stop R6");
    for (int i = 0; i < 40; i++) run(8'($urandom), (i % 5) == 0, "random");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule